// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block sequences a set of shared pads that carry configuration straps while the supply ramps and carry clocks once the chip is running. While the power-good input is low, the pads are left undriven and act as inputs. At the first reference-clock edge that sees power-good high, the block captures the five strap levels: the three frequency-select bits, the pin-function mode bit and the CPU output supply select. It then drives every clock pad low and starts a power-up timer. When the timer expires, it lets the clocks toggle.

The captured straps stay frozen for as long as power-good stays high. The block also supplies the frequency select that the synthesizer actually uses. This is either the strapped value or a select field supplied by software, chosen by a software-override bit. The mode strap decides whether the two shared pads are extra clock outputs or the pair of stop inputs. Dropping power-good returns the block to its input phase, so the next power-up captures the straps again.

Top module: `strap_seq`

## Requirements
- R1: While rstN is low, drvEn and clkRun are 0 and strapVal reads 5'h1F.
- R2: At the first clock edge where pwrGood is 1 while waiting, strapVal takes strapIn, and drvEn is 1 after that edge. Bit map: [0] FS0, [1] FS1, [2] FS2, [3] mode, [4] CPU low-voltage select.
- R3: Once captured, strapVal ignores any later change on strapIn for as long as pwrGood stays 1.
- R4: After the capture edge, drvEn is 1 and clkRun is 0 for exactly TIMER_CYCLES clock cycles.
- R5: clkRun becomes 1 at the TIMER_CYCLES-th edge after capture and stays 1 while pwrGood stays 1. clkRun is never 1 while drvEn is 0.
- R6: While waiting for power-good (pads undriven, drvEn 0), strapVal reads all ones, which is the pull-up level.
- R7: stopInputsEn is the inverse of the latched mode bit strapVal[3]. It is 1 when mode is 0, which makes the shared pads stop inputs, and 0 when mode is 1, which makes them clock outputs.
- R8: effFs equals swSel when swSelEn is 1 and strapVal[2:0] when swSelEn is 0. It follows swSelEn in the same cycle.
- R9: An edge that sees pwrGood at 0 leaves drvEn 0, clkRun 0 and strapVal all ones after it. The next rise of pwrGood captures strapIn again.
- R10: If pwrGood drops during the hold phase, the timer is abandoned. The following power-up waits a full TIMER_CYCLES again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply-good indication, synchronous to clk |
| strapIn | input | 5 | Levels seen on the shared pads |
| swSelEn | input | 1 | Software override of the frequency select |
| swSel | input | 3 | Software frequency select |
| drvEn | output | 1 | Pads driven (low until clkRun); 0 means high impedance |
| clkRun | output | 1 | Clock toggling enabled |
| strapVal | output | 5 | Latched straps |
| effFs | output | 3 | Effective frequency select |
| stopInputsEn | output | 1 | Shared pads act as stop inputs |

## Verification
The bench builds the block with TIMER_CYCLES set to 20 instead of the default of about 3 ms worth of reference clocks. With that setting, the exact last cycle of the hold phase, the first running cycle and a power-good loss in the middle of the hold can all be compared cycle by cycle. It also covers several full power cycles with different strap patterns. The default count is a plain counter limit and changes only the counter width.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  localparam int STRAP_W  = 5;
  localparam int FS_W     = 3;
  localparam int MODE_IDX = 3;

  typedef enum logic [1:0] {PH_WAIT, PH_HOLD, PH_RUN} phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } strap_ctl_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_seq_pkg::*;
#(
  parameter int TIMER_CYCLES = 42954
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  output strap_ctl_t ctl,
  output logic       drvEn,
  output logic       clkRun
);
  localparam int CNT_W = $clog2(TIMER_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMER_CYCLES - 1);

  phase_e          phase;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    ctl.clear   = !pwrGood;
    ctl.capture = pwrGood && (phase == PH_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_WAIT;
      holdCnt <= '0;
    end else if (!pwrGood) begin
      phase   <= PH_WAIT;
      holdCnt <= '0;
    end else begin
      case (phase)
        PH_WAIT: begin
          phase   <= PH_HOLD;
          holdCnt <= '0;
        end
        PH_HOLD: begin
          if (holdCnt == LAST) phase <= PH_RUN;
          else                 holdCnt <= holdCnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign drvEn  = (phase != PH_WAIT);
  assign clkRun = (phase == PH_RUN);
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strap_ctl_t         ctl,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               swSelEn,
  input  logic [FS_W-1:0]    swSel,
  output logic [STRAP_W-1:0] strapVal,
  output logic [FS_W-1:0]    effFs,
  output logic               stopInputsEn
);
  logic [STRAP_W-1:0] strapReg;

  // Each strap bit reads the pull-up level until it is captured
  for (genvar i = 0; i < STRAP_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            strapReg[i] <= 1'b1;
      else if (ctl.clear)   strapReg[i] <= 1'b1;
      else if (ctl.capture) strapReg[i] <= strapIn[i];
    end
  end

  assign strapVal     = strapReg;
  assign effFs        = swSelEn ? swSel : strapReg[FS_W-1:0];
  assign stopInputsEn = !strapReg[MODE_IDX];
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_seq_pkg::*;
#(
  parameter int TIMER_CYCLES = 42954
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGood,
  input  logic [4:0]  strapIn,
  input  logic        swSelEn,
  input  logic [2:0]  swSel,
  output logic        drvEn,
  output logic        clkRun,
  output logic [4:0]  strapVal,
  output logic [2:0]  effFs,
  output logic        stopInputsEn
);
  strap_ctl_t ctl;

  strap_ctrl #(.TIMER_CYCLES(TIMER_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood),
    .ctl(ctl), .drvEn(drvEn), .clkRun(clkRun)
  );

  strap_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .strapIn(strapIn),
    .swSelEn(swSelEn), .swSel(swSel),
    .strapVal(strapVal), .effFs(effFs), .stopInputsEn(stopInputsEn)
  );
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
  parameter int TIMER_CYCLES = 42954
) (
  input logic       clk,
  input logic       rstN,
  input logic       pwrGood,
  input logic [4:0] strapIn,
  input logic       drvEn,
  input logic       clkRun,
  input logic [4:0] strapVal
);
  localparam int HW = $clog2(TIMER_CYCLES + 2) + 1;
  logic [HW-1:0] holdSeen;

  // Counts hold cycles so the window length is checked without deep $past
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        holdSeen <= '0;
    else if (!drvEn)  holdSeen <= '0;
    else if (!clkRun) holdSeen <= holdSeen + 1'b1;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEn) |-> strapVal == $past(strapIn));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && $past(drvEn)) |-> $stable(strapVal));

  p_hold_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRun) |-> holdSeen == HW'(TIMER_CYCLES));

  p_run_driven_r5: assert property (@(posedge clk) disable iff (!rstN)
    clkRun |-> drvEn);

  p_pullup_r6: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> strapVal == 5'h1F);

  p_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (!drvEn && !clkRun));
endmodule

bind strap_seq strap_seq_chk #(.TIMER_CYCLES(TIMER_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .strapIn(strapIn),
  .drvEn(drvEn), .clkRun(clkRun), .strapVal(strapVal)
);

// File: tb/tb_strap_seq.sv
module tb_strap_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGood = 1'b0;
  logic [4:0] strapIn = 5'h00;
  logic       swSelEn = 1'b0;
  logic [2:0] swSel = 3'd0;
  logic       drvEn, clkRun, stopInputsEn;
  logic [4:0] strapVal;
  logic [2:0] effFs;

  strap_seq #(.TIMER_CYCLES(T)) dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .strapIn(strapIn),
    .swSelEn(swSelEn), .swSel(swSel), .drvEn(drvEn), .clkRun(clkRun),
    .strapVal(strapVal), .effFs(effFs), .stopInputsEn(stopInputsEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       drv;
    logic       run;
    logic [4:0] straps;
    logic [2:0] eff;
    logic       stopIn;
    string      tag;
  } exp_t;

  exp_t q[$];
  int nCmp = 0;
  int nBad = 0;

  // Reference model state
  int         mState = 0;
  int         mCnt = 0;
  logic [4:0] mStraps = 5'h1F;

  task automatic compare(input exp_t e);
    nCmp++;
    if (drvEn !== e.drv || clkRun !== e.run || strapVal !== e.straps ||
        effFs !== e.eff || stopInputsEn !== e.stopIn) begin
      nBad++;
      $display("FAIL %s: got drv=%b run=%b straps=%h eff=%0d stop=%b exp drv=%b run=%b straps=%h eff=%0d stop=%b",
               e.tag, drvEn, clkRun, strapVal, effFs, stopInputsEn,
               e.drv, e.run, e.straps, e.eff, e.stopIn);
    end
  endtask

  // Driver: apply inputs, advance the model, push the expected item
  task automatic step(input logic pg, input logic [4:0] pins,
                      input logic se, input logic [2:0] ss, input string tag);
    exp_t e;
    @(negedge clk);
    pwrGood = pg; strapIn = pins; swSelEn = se; swSel = ss;
    @(posedge clk);
    if (!pg) begin
      mState = 0; mStraps = 5'h1F; mCnt = 0;
    end else if (mState == 0) begin
      mState = 1; mStraps = pins; mCnt = 0;
    end else if (mState == 1) begin
      if (mCnt == T - 1) mState = 2;
      else mCnt++;
    end
    e.drv    = (mState != 0);
    e.run    = (mState == 2);
    e.straps = mStraps;
    e.eff    = se ? ss : mStraps[2:0];
    e.stopIn = !mStraps[3];
    e.tag    = tag;
    q.push_back(e);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) compare(q.pop_front());
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    exp_t r;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.drv = 0; r.run = 0; r.straps = 5'h1F; r.eff = 3'h7; r.stopIn = 0;
    r.tag = "R1 reset";
    compare(r);
    rstN = 1'b1;

    // R6 waiting for power-good reads pull-ups
    step(0, 5'h00, 0, 3'd0, "R6 waiting pull-up");
    step(0, 5'h0A, 0, 3'd0, "R6 waiting pins ignored");

    // R2 capture pattern mode=1, FS=010
    step(1, 5'h0A, 0, 3'd0, "R2 capture 0A");
    // R3 pin changes ignored, R4 hold, R5 run, R8 override
    for (int i = 0; i < T + 4; i++) begin
      if (i % 3 == 0)
        step(1, 5'h15 ^ 5'(i), 1, 3'(i), "R8 R4 R5 override during sequence");
      else
        step(1, 5'(i * 7), 0, 3'd5, "R3 R4 R5 pins ignored");
    end

    // R9 drop and recapture with mode=0
    step(0, 5'h15, 0, 3'd0, "R9 drop");
    step(0, 5'h15, 0, 3'd0, "R9 stay low");
    step(1, 5'h15, 0, 3'd0, "R2 R7 recapture mode0");
    step(1, 5'h1F, 0, 3'd0, "R7 stop inputs on mode0");

    // R10 drop mid-hold, then full timer again
    for (int i = 0; i < 5; i++) step(1, 5'h00, 0, 3'd0, "R10 partial hold");
    step(0, 5'h07, 0, 3'd0, "R10 abort hold");
    step(1, 5'h07, 0, 3'd0, "R10 R2 capture 07");
    for (int i = 0; i < T + 3; i++)
      step(1, 5'h18, (i == T), 3'd2, "R10 R4 R5 R8 full timer");
    step(1, 5'h18, 1, 3'd6, "R8 override 6");
    step(1, 5'h18, 0, 3'd6, "R8 strap select");

    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule